// File: doc/BRIEF.md
# Streaming Summed-Area Table Generator

This block takes a detector image as a raster-ordered stream of 16-bit pixels, several pixels per beat. It builds three summed-area tables side by side. The first counts valid pixels. The second accumulates pixel values. The third accumulates squared pixel values. Any pixel equal to a configurable invalid marker is treated as masked. A masked pixel counts as zero in the count table and adds nothing to the other two tables. The image width and height are compile-time parameters.

Each time the last beat of an image row is accepted, the block presents one row-wide output block. For every column, that block holds the three sums taken over the rectangle from the top-left pixel to that column. The block is offered with a valid/ready handshake, and the final row of a frame carries an end-of-frame flag. The row block currently on offer also serves as the previous-row input when the next row is accumulated. Input therefore keeps flowing at one beat per cycle, and stalls only when a row finishes while its predecessor is still untaken.

Row tracking runs through an enumerated machine with three states:
- `ST_TOP_ROW`: the previous-row contribution is forced to zero.
- `ST_INNER_ROW`: rows between the first and the last.
- `ST_BOTTOM_ROW`: the row whose block carries end-of-frame.

Transitions fire only when a row completes:
- `ST_TOP_ROW` goes to `ST_INNER_ROW`, or straight to `ST_BOTTOM_ROW` when the image has two rows.
- `ST_INNER_ROW` goes to `ST_BOTTOM_ROW` once the second-to-last row finishes.
- `ST_BOTTOM_ROW` returns to `ST_TOP_ROW`, which starts a new frame.

Top module: `sat_stream_gen`

## Requirements
- R1: A pixel is valid exactly when it differs from the invalid marker (default 16'hFFFF). The count table entry is the number of valid pixels in the rectangle, kept modulo 256 (8 bits).
- R2: A masked pixel adds zero to the value table and to the squared-value table.
- R3: The value table holds the sum of pixel values, and the squared-value table holds the sum of 32-bit squares. Both are kept modulo 2^32.
- R4: The entry for column c of the block for row r is the sum over all rows 0..r and columns 0..c. Column c sits at bits [c*8 +: 8] of `out_mask` and at bits [c*32 +: 32] of `out_sum` and `out_sq`.
- R5: Each input beat carries PACK pixels in raster order. Lane k sits at bits [k*16 +: 16] and is column beat*PACK + k.
- R6: `out_valid` is high in the cycle after the last beat of a row is accepted. `out_eof` is high only together with `out_valid`, and only on the block of the last image row.
- R7: While `out_valid` is high and `out_ready` is low, the block contents and `out_eof` hold steady.
- R8: `in_ready` is low only when the beat on offer is the last of its row while a block is still untaken (`out_valid` high, `out_ready` low). Otherwise one beat is accepted per cycle.
- R9: The first row of every frame uses a zero previous row, so consecutive frames do not leak into each other.
- R10: After reset, `out_valid` is low, `in_ready` is high, and the next beat accepted is the first beat of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel beat offered |
| in_ready | output | 1 | Pixel beat can be taken |
| in_pix | input | PACK*16 | PACK pixels, lane 0 leftmost |
| out_valid | output | 1 | Row block on offer |
| out_ready | input | 1 | Consumer takes the row block |
| out_eof | output | 1 | Block is the last row of the frame |
| out_mask | output | IMG_W*8 | Valid-count table row |
| out_sum | output | IMG_W*32 | Value-sum table row |
| out_sq | output | IMG_W*32 | Squared-value table row |

## Verification
The hardest situation to reach from the ports is a row that completes while the previous block is still untaken. This case matters because that held block is also the previous-row operand for the new row. A directed sequence holds `out_ready` low through a whole row and offers the next row's closing beat. It checks that the beat is refused and that the held block does not change. It then raises `out_ready` in the same cycle, so that the take and the accept coincide. Table-driven frames then vary the pixel pattern and the consumer's ready duty cycle. One pattern uses all-maximum valid values to make the squared sums wrap, and the count table passes 256 so that it wraps too. A mid-frame reset followed by a fresh frame checks that the row state is cleared.

// File: rtl/sat_pkg.sv
package sat_pkg;
    localparam int PIX_W  = 16;
    localparam int MASK_W = 8;
    localparam int ACC_W  = 32;

    typedef struct packed {
        logic [MASK_W-1:0] m;
        logic [ACC_W-1:0]  s;
        logic [ACC_W-1:0]  q;
    } sat_ent_t;

    localparam sat_ent_t ENT_ZERO = '{m: '0, s: '0, q: '0};

    function automatic sat_ent_t ent_add(input sat_ent_t a, input sat_ent_t b);
        sat_ent_t r;
        r.m = a.m + b.m;
        r.s = a.s + b.s;
        r.q = a.q + b.q;
        return r;
    endfunction
endpackage

// File: rtl/sat_lane_prep.sv
module sat_lane_prep
    import sat_pkg::*;
#(
    parameter logic [PIX_W-1:0] INVALID = 16'hFFFF
) (
    input  logic [PIX_W-1:0] pix,
    output sat_ent_t         ent
);
    logic             keep;
    logic [ACC_W-1:0] val;

    always_comb begin
        keep  = (pix != INVALID);
        val   = keep ? {{(ACC_W-PIX_W){1'b0}}, pix} : '0;
        ent.m = {{(MASK_W-1){1'b0}}, keep};
        ent.s = val;
        ent.q = val * val;
    end
endmodule

// File: rtl/sat_pack_scan.sv
module sat_pack_scan
    import sat_pkg::*;
#(
    parameter int PACK = 4
) (
    input  sat_ent_t            carry_in,
    input  sat_ent_t [PACK-1:0] lanes,
    output sat_ent_t [PACK-1:0] pref
);
    always_comb begin
        sat_ent_t run;
        run = carry_in;
        for (int k = 0; k < PACK; k++) begin
            run     = ent_add(run, lanes[k]);
            pref[k] = run;
        end
    end
endmodule

// File: rtl/sat_stream_gen.sv
module sat_stream_gen
    import sat_pkg::*;
#(
    parameter int                IMG_W   = 16,
    parameter int                IMG_H   = 4,
    parameter int                PACK    = 4,
    parameter logic [PIX_W-1:0]  INVALID = 16'hFFFF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [PACK*PIX_W-1:0]   in_pix,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic                    out_eof,
    output logic [IMG_W*MASK_W-1:0] out_mask,
    output logic [IMG_W*ACC_W-1:0]  out_sum,
    output logic [IMG_W*ACC_W-1:0]  out_sq
);
    localparam int BEATS  = IMG_W / PACK;
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int ROW_W  = (IMG_H > 1) ? $clog2(IMG_H) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
    localparam logic [ROW_W-1:0]  PENULT    = ROW_W'(IMG_H - 2);

    typedef enum logic [1:0] {
        ST_TOP_ROW,
        ST_INNER_ROW,
        ST_BOTTOM_ROW
    } row_state_t;

    row_state_t state_q, state_d;

    logic [BEAT_W-1:0]              beat_q;
    logic [ROW_W-1:0]               row_q;
    sat_ent_t                       carry_q;
    sat_ent_t [BEATS-1:0][PACK-1:0] cur_q;
    sat_ent_t [BEATS-1:0][PACK-1:0] blk_q;

    sat_ent_t [PACK-1:0] lane_ent;
    sat_ent_t [PACK-1:0] lane_pref;
    sat_ent_t [PACK-1:0] new_ent;
    sat_ent_t            carry_in;

    logic last_beat, accept, row_done;

    assign last_beat = (beat_q == LAST_BEAT);
    assign in_ready  = !(last_beat && out_valid && !out_ready);
    assign accept    = in_valid && in_ready;
    assign row_done  = accept && last_beat;
    assign carry_in  = (beat_q == '0) ? ENT_ZERO : carry_q;

    // per-lane masking and squaring
    for (genvar k = 0; k < PACK; k++) begin : g_lane
        sat_lane_prep #(.INVALID(INVALID)) u_prep (
            .pix (in_pix[k*PIX_W +: PIX_W]),
            .ent (lane_ent[k])
        );
    end

    sat_pack_scan #(.PACK(PACK)) u_scan (
        .carry_in (carry_in),
        .lanes    (lane_ent),
        .pref     (lane_pref)
    );

    // add the previous row; the top row of a frame sees zero
    always_comb begin
        for (int k = 0; k < PACK; k++) begin
            new_ent[k] = (state_q == ST_TOP_ROW) ? lane_pref[k]
                                                 : ent_add(lane_pref[k], blk_q[beat_q][k]);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_TOP_ROW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TOP_ROW:    if (row_done) state_d = (IMG_H > 2) ? ST_INNER_ROW : ST_BOTTOM_ROW;
            ST_INNER_ROW:  if (row_done && row_q == PENULT) state_d = ST_BOTTOM_ROW;
            ST_BOTTOM_ROW: if (row_done) state_d = ST_TOP_ROW;
            default:       state_d = ST_TOP_ROW;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q    <= '0;
            row_q     <= '0;
            carry_q   <= ENT_ZERO;
            cur_q     <= '0;
            blk_q     <= '0;
            out_valid <= 1'b0;
            out_eof   <= 1'b0;
        end else begin
            if (accept) begin
                cur_q[beat_q] <= new_ent;
                carry_q       <= lane_pref[PACK-1];
                beat_q        <= last_beat ? '0 : beat_q + 1'b1;
            end
            if (row_done) begin
                for (int b = 0; b < BEATS - 1; b++) blk_q[b] <= cur_q[b];
                blk_q[BEATS-1] <= new_ent;
                row_q     <= (state_q == ST_BOTTOM_ROW) ? '0 : row_q + 1'b1;
                out_valid <= 1'b1;
                out_eof   <= (state_q == ST_BOTTOM_ROW);
            end else if (out_ready) begin
                out_valid <= 1'b0;
                out_eof   <= 1'b0;
            end
        end
    end

    // flatten the held block onto the ports
    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        for (genvar k = 0; k < PACK; k++) begin : g_col
            localparam int COL = b * PACK + k;
            assign out_mask[COL*MASK_W +: MASK_W] = blk_q[b][k].m;
            assign out_sum [COL*ACC_W  +: ACC_W]  = blk_q[b][k].s;
            assign out_sq  [COL*ACC_W  +: ACC_W]  = blk_q[b][k].q;
        end
    end
endmodule

// File: rtl/sat_stream_gen_chk.sv
module sat_stream_gen_chk #(
    parameter int IMG_W = 16,
    parameter int PACK  = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic                 out_eof,
    input logic [IMG_W*8-1:0]   out_mask,
    input logic [IMG_W*32-1:0]  out_sum,
    input logic [IMG_W*32-1:0]  out_sq
);
    localparam int BEATS = IMG_W / PACK;

    int seen;
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 0;
        else if (in_valid && in_ready) seen <= (seen == BEATS - 1) ? 0 : seen + 1;
    end

    a_r7_block_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_mask) && $stable(out_sum)
                                    && $stable(out_sq) && $stable(out_eof));

    a_r8_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid && !out_ready);

    a_r8_midrow_ready: assert property (@(posedge clk) disable iff (!rst_n)
        seen != BEATS - 1 |-> in_ready);

    a_r6_eof_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid);

    a_r6_row_emits: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && seen == BEATS - 1 |=> out_valid);
endmodule

bind sat_stream_gen sat_stream_gen_chk #(.IMG_W(IMG_W), .PACK(PACK)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_eof(out_eof),
    .out_mask(out_mask), .out_sum(out_sum), .out_sq(out_sq)
);

// File: tb/sim_sat_stream_gen.sv
module sim_sat_stream_gen;
    localparam int TW = 32;
    localparam int TH = 10;
    localparam int TP = 4;
    localparam int NB = TW / TP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [TP*16-1:0] in_pix = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic out_eof;
    logic [TW*8-1:0]  out_mask;
    logic [TW*32-1:0] out_sum;
    logic [TW*32-1:0] out_sq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [7:0]  em [TH][TW];
    logic [31:0] es [TH][TW];
    logic [31:0] eq [TH][TW];

    // pattern, consumer ready mode
    localparam int VEC [5][2] = '{'{0, 0}, '{1, 1}, '{2, 0}, '{3, 2}, '{3, 1}};

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sat_stream_gen #(.IMG_W(TW), .IMG_H(TH), .PACK(TP)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
        .out_eof(out_eof), .out_mask(out_mask), .out_sum(out_sum), .out_sq(out_sq)
    );

    function automatic logic [15:0] pix_of(int pat, int r, int c);
        case (pat)
            0: return 16'(r * TW + c + 1);
            1: return 16'hFFFF;
            2: return 16'hFFFE;
            default: return (((r * 7 + c * 3) % 5) == 0) ? 16'hFFFF
                            : 16'((r * 131 + c * 977) & 16'h3FFF);
        endcase
    endfunction

    function automatic bit ready_of(int bp, int cy);
        case (bp)
            0: return 1'b1;
            1: return (cy % 3) != 0;
            default: return (cy % 4) == 0;
        endcase
    endfunction

    task automatic compute_exp(int pat);
        for (int r = 0; r < TH; r++) begin
            for (int c = 0; c < TW; c++) begin
                logic [15:0] v;
                logic [31:0] z;
                logic [7:0]  mm;
                v  = pix_of(pat, r, c);
                mm = (v != 16'hFFFF) ? 8'd1 : 8'd0;
                z  = (v != 16'hFFFF) ? {16'h0, v} : 32'h0;
                em[r][c] = mm;
                es[r][c] = z;
                eq[r][c] = z * z;
                if (r > 0) begin
                    em[r][c] += em[r-1][c]; es[r][c] += es[r-1][c]; eq[r][c] += eq[r-1][c];
                end
                if (c > 0) begin
                    em[r][c] += em[r][c-1]; es[r][c] += es[r][c-1]; eq[r][c] += eq[r][c-1];
                end
                if (r > 0 && c > 0) begin
                    em[r][c] -= em[r-1][c-1]; es[r][c] -= es[r-1][c-1]; eq[r][c] -= eq[r-1][c-1];
                end
            end
        end
    endtask

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R1 R2 R3 R4 R6: compare the presented block with row r of the model
    task automatic check_row(int r);
        int bm, bs, bq;
        bm = -1; bs = -1; bq = -1;
        for (int c = TW - 1; c >= 0; c--) begin
            if (out_mask[c*8 +: 8]  != em[r][c]) bm = c;
            if (out_sum[c*32 +: 32] != es[r][c]) bs = c;
            if (out_sq[c*32 +: 32]  != eq[r][c]) bq = c;
        end
        check(bm < 0, "R1", $sformatf("mask row %0d col %0d", r, bm),
              bm < 0 ? 0 : out_mask[bm*8 +: 8], bm < 0 ? 0 : em[r][bm]);
        check(bs < 0, "R2/R4", $sformatf("sum row %0d col %0d", r, bs),
              bs < 0 ? 0 : out_sum[bs*32 +: 32], bs < 0 ? 0 : es[r][bs]);
        check(bq < 0, "R3", $sformatf("sq row %0d col %0d", r, bq),
              bq < 0 ? 0 : out_sq[bq*32 +: 32], bq < 0 ? 0 : eq[r][bq]);
        check(out_eof == (r == TH - 1), "R6", $sformatf("eof row %0d", r),
              out_eof, r == TH - 1);
    endtask

    function automatic logic [TP*16-1:0] beat_of(int pat, int r, int b);
        logic [TP*16-1:0] v;
        for (int k = 0; k < TP; k++) v[k*16 +: 16] = pix_of(pat, r, b * TP + k); // R5 lane order
        return v;
    endfunction

    task automatic send_frame(int pat);
        for (int r = 0; r < TH; r++) begin
            for (int b = 0; b < NB; b++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_pix   = beat_of(pat, r, b);
                #4;
                check(in_ready == !(b == NB - 1 && out_valid && !out_ready), "R8",
                      "in_ready", in_ready, !(b == NB - 1 && out_valid && !out_ready));
                while (!in_ready) begin
                    @(negedge clk);
                    #4;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic collect_frame(int bp);
        int r;
        logic [TW*32-1:0] held;
        bit held_ok;
        r = 0;
        held_ok = 0;
        while (r < TH) begin
            @(negedge clk);
            out_ready = ready_of(bp, cyc);
            #4;
            if (held_ok && out_valid)
                check(out_sum == held, "R7", "held block changed", 0, 0);
            held_ok = out_valid && !out_ready;
            held    = out_sum;
            if (out_valid && out_ready) begin
                check_row(r);
                r++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #4;
        check(out_valid == 0, "R10", "out_valid after reset", out_valid, 0);
        check(in_ready == 1, "R10", "in_ready after reset", in_ready, 1);

        // directed: completion of a row while the previous block is held
        compute_exp(0);
        for (int b = 0; b < NB; b++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_pix   = beat_of(0, 0, b);
            #4;
            check(in_ready == 1, "R8", "row0 beat ready", in_ready, 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        #4;
        check(out_valid == 1, "R6", "valid after row end", out_valid, 1);
        check_row(0);
        for (int b = 0; b < NB - 1; b++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_pix   = beat_of(0, 1, b);
            #4;
            check(in_ready == 1, "R8", "row1 midrow ready", in_ready, 1);
        end
        @(negedge clk);
        in_pix = beat_of(0, 1, NB - 1);
        #4;
        check(in_ready == 0, "R8", "last beat stalled", in_ready, 0);
        @(negedge clk);
        #4;
        check(in_ready == 0, "R8", "stall persists", in_ready, 0);
        check_row(0); // R7: block unchanged while stalled
        @(negedge clk);
        out_ready = 1'b1;
        #4;
        check(in_ready == 1, "R8", "ready on take", in_ready, 1);
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b0;
        #4;
        check(out_valid == 1, "R6", "row1 presented", out_valid, 1);
        check_row(1);

        // mid-frame reset
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #4;
        check(out_valid == 0, "R10", "out_valid after mid reset", out_valid, 0);
        check(in_ready == 1, "R10", "in_ready after mid reset", in_ready, 1);

        // table-driven frames, back to back (R9 across frame boundaries)
        for (int i = 0; i < 5; i++) begin
            compute_exp(VEC[i][0]);
            fork
                send_frame(VEC[i][0]);
                collect_frame(VEC[i][1]);
            join
        end

        done = 1;
        finish_run();
    end
endmodule